// File: doc/BRIEF.md
# Dual Linear/Physical Tag Lookup

This block manages the tag store of a 4-way set-associative cache in which every line keeps two tags: one taken from the linear (pre-translation) address and one from the physical address. A lookup presents a set index, the linear tag and the already translated physical tag. The linear tags of the selected set are compared first. Only when none of them matches are the physical tags compared. A physical match then counts as a hit, and in the same cycle that way's linear tag is rewritten from the lookup's linear tag and marked valid. This is called tag recovery. A lookup that matches neither tag set is reported as a miss, together with its index, so that an external fill engine can act on it.

Each tag type has its own valid bits. This lets a line stay resident with only its physical tag valid. Two groups of bulk invalidation inputs exist. The narrow group (physical-side invalidate request, init) drops every linear valid bit. The wide group (flush, invalidate-all command) drops every valid bit of both types. Either group takes effect in one clock. A fill port writes both tags of one way. Data arrays, translation and the fill sequence itself belong to other blocks.

Top module: `dual_tag_lookup`

## Requirements
- R1: With `req_vld_i` high, when a valid linear tag in the indexed set equals `req_ltag_i`, `hit_o` and `lin_hit_o` are 1 and `recover_o` is 0 in the same cycle. `hit_way_o` gives the binary way number (0 to 3), and the lowest-numbered matching way wins.
- R2: With `req_vld_i` high, when no linear tag matches but a valid physical tag in the set equals `req_ptag_i`, `hit_o` and `recover_o` are 1, `lin_hit_o` is 0, and `hit_way_o` gives that way. All of this appears in the same cycle as the request.
- R3: The clock edge that ends a recovery cycle writes the request's linear tag into the recovered way and sets its linear valid bit. From the next cycle on, a lookup with that linear tag hits on the linear side in that way, and the linear tag that was there before no longer matches.
- R4: With `req_vld_i` high and no match in either tag set, `miss_o` is 1, `hit_o` is 0, `hit_way_o` is 0 and `miss_idx_o` equals `req_idx_i`.
- R5: Physical tags are consulted only on a linear miss. When a linear match exists, the linear way is reported and `recover_o` stays 0, even if another way's physical tag matches.
- R6: A pulse on `ptag_inv_i` or on `init_i` clears every linear valid bit and leaves the physical valid bits alone. A later lookup of such a line recovers instead of hitting on the linear side.
- R7: A pulse on `flush_i` or on `inv_all_i` clears every linear and physical valid bit, so later lookups miss.
- R8: A fill (`fill_en_i`) writes both tags of way `fill_way_i` in set `fill_idx_i` and marks both valid at the next clock edge.
- R9: After asynchronous reset (`rst_ni` low), every valid bit of both types is 0.
- R10: A bulk clear in the same cycle as a fill or a recovery wins: after that edge the affected valid bits are 0.
- R11: A fill and a recovery that target the same set and way in one cycle leave the fill's linear tag in place.
- R12: With `req_vld_i` low, `hit_o`, `lin_hit_o`, `recover_o` and `miss_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_vld_i | input | 1 | Lookup request valid |
| req_idx_i | input | IDX_W | Lookup set index |
| req_ltag_i | input | LTAG_W | Lookup linear tag |
| req_ptag_i | input | PTAG_W | Lookup translated physical tag |
| fill_en_i | input | 1 | Write both tags of one way |
| fill_idx_i | input | IDX_W | Fill set index |
| fill_way_i | input | WAY_W | Fill way |
| fill_ltag_i | input | LTAG_W | Fill linear tag |
| fill_ptag_i | input | PTAG_W | Fill physical tag |
| ptag_inv_i | input | 1 | Physical-side invalidate request; clears linear valids |
| init_i | input | 1 | Init; clears linear valids |
| flush_i | input | 1 | Flush; clears all valids |
| inv_all_i | input | 1 | Invalidate-all command; clears all valids |
| hit_o | output | 1 | Lookup hit (linear or physical) |
| lin_hit_o | output | 1 | Hit found on the linear tags |
| recover_o | output | 1 | Physical hit with linear tag rewrite |
| hit_way_o | output | WAY_W | Hitting way number |
| miss_o | output | 1 | Lookup missed both tag sets |
| miss_idx_o | output | IDX_W | Index of the missing lookup |

## Verification
The bench aims at the following corner cases. The first is a recovered line on a later lookup: if the linear rewrite was lost or went to the wrong way, it would keep recovering or would hit in the wrong way. The second is a set where one way matches on the linear side and a different way matches on the physical side: a design that checks the physical tags eagerly would report the wrong way or raise recovery. The bench also runs each of the narrow clears and each of the wide clears, since a design with swapped scopes would either lose resident lines or keep stale ones. Finally, it issues clear-versus-write and fill-versus-recovery collisions in a single cycle, where a wrong priority leaves a valid bit set or a stale tag in place.

// File: rtl/dual_tag_pkg.sv
package dual_tag_pkg;
  // which tag types a bulk clear touches
  typedef struct packed {
    logic lin;
    logic phys;
  } clr_scope_t;

  function automatic clr_scope_t clr_scope(input logic ptag_inv, input logic init,
                                           input logic flush, input logic inv_all);
    clr_scope_t s;
    s.phys = flush | inv_all;
    s.lin  = s.phys | ptag_inv | init;
    return s;
  endfunction
endpackage

// File: rtl/dtag_store.sv
module dtag_store #(
  parameter int SETS_LG = 4,
  parameter int WAYS    = 4,
  parameter int TAG_W   = 20,
  localparam int WAY_W  = $clog2(WAYS),
  localparam int PTR_W  = SETS_LG + WAY_W,
  localparam int ENTRIES = (1 << SETS_LG) * WAYS
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  // port a: higher priority
  input  logic                  wa_en_i,
  input  logic [SETS_LG-1:0]    wa_idx_i,
  input  logic [WAY_W-1:0]      wa_way_i,
  input  logic [TAG_W-1:0]      wa_tag_i,
  input  logic                  wb_en_i,
  input  logic [SETS_LG-1:0]    wb_idx_i,
  input  logic [WAY_W-1:0]      wb_way_i,
  input  logic [TAG_W-1:0]      wb_tag_i,
  input  logic [SETS_LG-1:0]    rd_idx_i,
  output logic [WAYS-1:0][TAG_W-1:0] rd_tag_o,
  output logic [WAYS-1:0]       rd_vld_o
);
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q;
  logic [PTR_W-1:0]   wa_ptr, wb_ptr;

  assign wa_ptr = {wa_idx_i, wa_way_i};
  assign wb_ptr = {wb_idx_i, wb_way_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
    end else if (clr_i) begin
      vld_q <= '0;
    end else begin
      if (wb_en_i) vld_q[wb_ptr] <= 1'b1;
      if (wa_en_i) vld_q[wa_ptr] <= 1'b1;
    end
  end

  // tags hold no reset; port a written last so it wins
  always_ff @(posedge clk_i) begin
    if (wb_en_i) tag_q[wb_ptr] <= wb_tag_i;
    if (wa_en_i) tag_q[wa_ptr] <= wa_tag_i;
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    localparam logic [WAY_W-1:0] WSEL = WAY_W'(w);
    assign rd_tag_o[w] = tag_q[{rd_idx_i, WSEL}];
    assign rd_vld_o[w] = vld_q[{rd_idx_i, WSEL}];
  end

  assert_clear_empties_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (vld_q == '0));

  assert_clear_beats_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && (wa_en_i || wb_en_i)) |=> ($countones(vld_q) == 0));

  assert_port_b_lands_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_en_i && !clr_i && !(wa_en_i && (wa_ptr == wb_ptr)))
      |=> (vld_q[$past(wb_ptr)] && (tag_q[$past(wb_ptr)] == $past(wb_tag_i))));

  assert_port_a_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wa_en_i && !clr_i) |=> (vld_q[$past(wa_ptr)] && (tag_q[$past(wa_ptr)] == $past(wa_tag_i))));
endmodule

// File: rtl/dtag_match.sv
module dtag_match #(
  parameter int WAYS   = 4,
  parameter int TAG_W  = 20,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][TAG_W-1:0] tag_i,
  input  logic [WAYS-1:0]            vld_i,
  input  logic [TAG_W-1:0]           key_i,
  output logic                       any_o,
  output logic [WAY_W-1:0]           way_o
);
  logic [WAYS-1:0] match;
  logic [WAYS-1:0] first;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = vld_i[w] && (tag_i[w] == key_i);
  end

  // lowest way wins
  always_comb begin
    way_o = '0;
    first = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) begin
        way_o = WAY_W'(w);
        first = '0;
        first[w] = 1'b1;
      end
    end
  end

  assign any_o = |match;

  always_comb begin
    assert_first_onehot_R1: assert ($onehot0(first) && (any_o == (first != '0)));
  end
endmodule

// File: rtl/dual_tag_lookup.sv
module dual_tag_lookup
  import dual_tag_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int WAYS   = 4,
  parameter int LTAG_W = 20,
  parameter int PTAG_W = 20,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_vld_i,
  input  logic [IDX_W-1:0]  req_idx_i,
  input  logic [LTAG_W-1:0] req_ltag_i,
  input  logic [PTAG_W-1:0] req_ptag_i,
  input  logic              fill_en_i,
  input  logic [IDX_W-1:0]  fill_idx_i,
  input  logic [WAY_W-1:0]  fill_way_i,
  input  logic [LTAG_W-1:0] fill_ltag_i,
  input  logic [PTAG_W-1:0] fill_ptag_i,
  input  logic              ptag_inv_i,
  input  logic              init_i,
  input  logic              flush_i,
  input  logic              inv_all_i,
  output logic              hit_o,
  output logic              lin_hit_o,
  output logic              recover_o,
  output logic [WAY_W-1:0]  hit_way_o,
  output logic              miss_o,
  output logic [IDX_W-1:0]  miss_idx_o
);
  clr_scope_t scope;
  logic [WAYS-1:0][LTAG_W-1:0] lin_tags;
  logic [WAYS-1:0][PTAG_W-1:0] phys_tags;
  logic [WAYS-1:0]             lin_vld, phys_vld;
  logic                        lin_any, phys_any;
  logic [WAY_W-1:0]            lin_way, phys_way;
  logic                        recover;

  assign scope = clr_scope(ptag_inv_i, init_i, flush_i, inv_all_i);

  dtag_store #(.SETS_LG(IDX_W), .WAYS(WAYS), .TAG_W(LTAG_W)) u_lin_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (scope.lin),
    .wa_en_i  (fill_en_i),
    .wa_idx_i (fill_idx_i),
    .wa_way_i (fill_way_i),
    .wa_tag_i (fill_ltag_i),
    .wb_en_i  (recover),
    .wb_idx_i (req_idx_i),
    .wb_way_i (phys_way),
    .wb_tag_i (req_ltag_i),
    .rd_idx_i (req_idx_i),
    .rd_tag_o (lin_tags),
    .rd_vld_o (lin_vld)
  );

  dtag_store #(.SETS_LG(IDX_W), .WAYS(WAYS), .TAG_W(PTAG_W)) u_phys_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (scope.phys),
    .wa_en_i  (fill_en_i),
    .wa_idx_i (fill_idx_i),
    .wa_way_i (fill_way_i),
    .wa_tag_i (fill_ptag_i),
    .wb_en_i  (1'b0),
    .wb_idx_i ('0),
    .wb_way_i ('0),
    .wb_tag_i ('0),
    .rd_idx_i (req_idx_i),
    .rd_tag_o (phys_tags),
    .rd_vld_o (phys_vld)
  );

  dtag_match #(.WAYS(WAYS), .TAG_W(LTAG_W)) u_lin_match (
    .tag_i (lin_tags),
    .vld_i (lin_vld),
    .key_i (req_ltag_i),
    .any_o (lin_any),
    .way_o (lin_way)
  );

  dtag_match #(.WAYS(WAYS), .TAG_W(PTAG_W)) u_phys_match (
    .tag_i (phys_tags),
    .vld_i (phys_vld),
    .key_i (req_ptag_i),
    .any_o (phys_any),
    .way_o (phys_way)
  );

  // physical result only matters on a linear miss
  assign recover    = req_vld_i && !lin_any && phys_any;
  assign lin_hit_o  = req_vld_i && lin_any;
  assign recover_o  = recover;
  assign hit_o      = lin_hit_o || recover;
  assign miss_o     = req_vld_i && !lin_any && !phys_any;
  assign miss_idx_o = miss_o ? req_idx_i : '0;

  always_comb begin
    hit_way_o = '0;
    if (lin_hit_o)    hit_way_o = lin_way;
    else if (recover) hit_way_o = phys_way;
  end

  assert_recover_not_lin_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recover_o |-> (!lin_hit_o && hit_o));

  assert_miss_exclusive_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |-> (!hit_o && (miss_idx_o == req_idx_i) && (hit_way_o == '0)));

  assert_idle_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_vld_i |-> !(hit_o || miss_o || recover_o || lin_hit_o));

  assert_recovered_hits_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (recover_o && !scope.lin && !(fill_en_i && (fill_idx_i == req_idx_i)))
      |=> ((req_vld_i && (req_idx_i == $past(req_idx_i)) && (req_ltag_i == $past(req_ltag_i)))
           -> lin_hit_o));

  assert_flush_misses_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scope.phys && !fill_en_i) |=> (req_vld_i -> miss_o));
endmodule

// File: tb/dual_tag_lookup_tb.sv
module dual_tag_lookup_tb;
  localparam int IDX_W = 4, WAYS = 4, LTAG_W = 20, PTAG_W = 20, WAY_W = 2;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_vld_i = 0, fill_en_i = 0, ptag_inv_i = 0, init_i = 0, flush_i = 0, inv_all_i = 0;
  logic [IDX_W-1:0]  req_idx_i = '0, fill_idx_i = '0;
  logic [LTAG_W-1:0] req_ltag_i = '0, fill_ltag_i = '0;
  logic [PTAG_W-1:0] req_ptag_i = '0, fill_ptag_i = '0;
  logic [WAY_W-1:0]  fill_way_i = '0;
  logic hit_o, lin_hit_o, recover_o, miss_o;
  logic [WAY_W-1:0] hit_way_o;
  logic [IDX_W-1:0] miss_idx_o;

  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dual_tag_lookup #(.IDX_W(IDX_W), .WAYS(WAYS), .LTAG_W(LTAG_W), .PTAG_W(PTAG_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_vld_i(req_vld_i), .req_idx_i(req_idx_i), .req_ltag_i(req_ltag_i), .req_ptag_i(req_ptag_i),
    .fill_en_i(fill_en_i), .fill_idx_i(fill_idx_i), .fill_way_i(fill_way_i),
    .fill_ltag_i(fill_ltag_i), .fill_ptag_i(fill_ptag_i),
    .ptag_inv_i(ptag_inv_i), .init_i(init_i), .flush_i(flush_i), .inv_all_i(inv_all_i),
    .hit_o(hit_o), .lin_hit_o(lin_hit_o), .recover_o(recover_o), .hit_way_o(hit_way_o),
    .miss_o(miss_o), .miss_idx_o(miss_idx_o)
  );

  typedef struct packed {
    logic [1:0]  op;   // 1 fill, 2 lookup
    logic [3:0]  idx;
    logic [1:0]  way;
    logic [19:0] lt;
    logic [19:0] pt;
    logic        e_hit, e_lin, e_rec, e_miss;
    logic [1:0]  e_way;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 4'd3, 2'd2, 20'hA1, 20'hB1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 4'd8},  // R8
    '{2'd2, 4'd3, 2'd0, 20'hA1, 20'h00, 1'b1, 1'b1, 1'b0, 1'b0, 2'd2, 4'd1},  // R1
    '{2'd2, 4'd3, 2'd0, 20'hA2, 20'hB1, 1'b1, 1'b0, 1'b1, 1'b0, 2'd2, 4'd2},  // R2
    '{2'd2, 4'd3, 2'd0, 20'hA2, 20'h00, 1'b1, 1'b1, 1'b0, 1'b0, 2'd2, 4'd3},  // R3
    '{2'd2, 4'd3, 2'd0, 20'hA1, 20'h00, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 4'd3},  // R3 old tag gone
    '{2'd1, 4'd3, 2'd0, 20'hC1, 20'hD1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 4'd8},  // R8
    '{2'd2, 4'd5, 2'd0, 20'hC1, 20'hD1, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 4'd4},  // R4
    '{2'd2, 4'd3, 2'd0, 20'hC1, 20'hB1, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 4'd5},  // R5
    '{2'd2, 4'd3, 2'd0, 20'hF1, 20'hD1, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 4'd2},  // R2
    '{2'd1, 4'd3, 2'd1, 20'hA2, 20'hE1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 4'd8},  // R8
    '{2'd2, 4'd3, 2'd0, 20'hA2, 20'h00, 1'b1, 1'b1, 1'b0, 1'b0, 2'd1, 4'd1},  // R1 lowest way
    '{2'd2, 4'd3, 2'd0, 20'hF1, 20'h00, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 4'd3}   // R3
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input logic eh, input logic el, input logic er,
                         input logic em, input logic [1:0] ew, input logic [3:0] eidx);
    chk(req, "hit", hit_o, eh);
    chk(req, "lin_hit", lin_hit_o, el);
    chk(req, "recover", recover_o, er);
    chk(req, "miss", miss_o, em);
    chk(req, "way", hit_way_o, ew);
    chk(req, "miss_idx", miss_idx_o, em ? eidx : 4'd0);
  endtask

  task automatic quiet();
    req_vld_i = 0; fill_en_i = 0; ptag_inv_i = 0; init_i = 0; flush_i = 0; inv_all_i = 0;
  endtask

  // inputs change 1 ns after a rising edge; outputs are sampled mid-cycle
  task automatic next();
    @(posedge clk); #1;
    quiet();
  endtask

  task automatic do_fill(input logic [3:0] idx, input logic [1:0] way, input logic [19:0] lt, input logic [19:0] pt);
    fill_en_i = 1; fill_idx_i = idx; fill_way_i = way; fill_ltag_i = lt; fill_ptag_i = pt;
  endtask

  task automatic do_look(input logic [3:0] idx, input logic [19:0] lt, input logic [19:0] pt);
    req_vld_i = 1; req_idx_i = idx; req_ltag_i = lt; req_ptag_i = pt;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    next();

    // R12: idle outputs
    #9 chk_out("R12", 0, 0, 0, 0, 2'd0, 4'd0);
    // R9: empty after reset
    next(); do_look(4'd3, 20'hA1, 20'hB1);
    #9 chk_out("R9", 0, 0, 0, 1, 2'd0, 4'd3);

    for (int i = 0; i < NV; i++) begin
      next();
      if (VECS[i].op == 2'd1) do_fill(VECS[i].idx, VECS[i].way, VECS[i].lt, VECS[i].pt);
      else do_look(VECS[i].idx, VECS[i].lt, VECS[i].pt);
      #9;
      if (VECS[i].op == 2'd2)
        chk_out($sformatf("R%0d vec%0d", VECS[i].rq, i), VECS[i].e_hit, VECS[i].e_lin,
                VECS[i].e_rec, VECS[i].e_miss, VECS[i].e_way, VECS[i].idx);
    end

    // R6: ptag_inv keeps physical tags
    next(); do_fill(4'd7, 2'd3, 20'h11, 20'h22);
    next(); ptag_inv_i = 1;
    next(); do_look(4'd7, 20'h11, 20'h22);
    #9 chk_out("R6 ptag_inv", 1, 0, 1, 0, 2'd3, 4'd7);
    next(); do_look(4'd7, 20'h11, 20'h22);
    #9 chk_out("R6 restored", 1, 1, 0, 0, 2'd3, 4'd7);
    // R6: init
    next(); init_i = 1;
    next(); do_look(4'd7, 20'h11, 20'h22);
    #9 chk_out("R6 init", 1, 0, 1, 0, 2'd3, 4'd7);

    // R7: flush
    next(); flush_i = 1;
    next(); do_look(4'd7, 20'h11, 20'h22);
    #9 chk_out("R7 flush", 0, 0, 0, 1, 2'd0, 4'd7);
    // R7: invalidate-all
    next(); do_fill(4'd7, 2'd1, 20'h33, 20'h44);
    next(); inv_all_i = 1;
    next(); do_look(4'd7, 20'h33, 20'h44);
    #9 chk_out("R7 inv_all", 0, 0, 0, 1, 2'd0, 4'd7);

    // R10: flush with same-cycle fill
    next(); do_fill(4'd8, 2'd1, 20'h55, 20'h66); flush_i = 1;
    next(); do_look(4'd8, 20'h55, 20'h66);
    #9 chk_out("R10 fill+flush", 0, 0, 0, 1, 2'd0, 4'd8);
    // R10: init with same-cycle recovery
    next(); do_fill(4'd9, 2'd2, 20'h77, 20'h88);
    next(); ptag_inv_i = 1;
    next(); do_look(4'd9, 20'h79, 20'h88); init_i = 1;
    #9 chk_out("R10 recover+init", 1, 0, 1, 0, 2'd2, 4'd9);
    next(); do_look(4'd9, 20'h79, 20'h88);
    #9 chk_out("R10 rewrite dropped", 1, 0, 1, 0, 2'd2, 4'd9);

    // R11: fill and recovery on one way
    next(); do_fill(4'd10, 2'd0, 20'h01, 20'h02);
    next(); ptag_inv_i = 1;
    next(); do_look(4'd10, 20'h05, 20'h02); do_fill(4'd10, 2'd0, 20'h06, 20'h07);
    #9 chk_out("R11 recover seen", 1, 0, 1, 0, 2'd0, 4'd10);
    next(); do_look(4'd10, 20'h06, 20'h00);
    #9 chk_out("R11 fill tag", 1, 1, 0, 0, 2'd0, 4'd10);
    next(); do_look(4'd10, 20'h05, 20'h00);
    #9 chk_out("R11 recover tag lost", 0, 0, 0, 1, 2'd0, 4'd10);

    next();
    #9 chk_out("R12 end", 0, 0, 0, 0, 2'd0, 4'd0);
    finish_run();
  end
endmodule